// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block is the command front end of a serial memory for everything that touches the status byte. It listens to a mode 0 serial bus: data is sampled on rising serial clock edges while the active-low select is held low. It recognises three one-byte commands: set the write enable latch, read the status byte, and write the status byte. The serial pins are assumed to be synchronous to the system clock. The block finds serial clock and select edges by comparing each pin with its value one system clock earlier.

A status write is taken only when the enable latch is set and the status byte is not locked. Select must also rise with exactly sixteen bits clocked in. An accepted write launches a timed busy period whose length is a parameter in system clocks. The incoming protection bits wait in a holding register and replace the visible ones only when that period ends. The enable latch clears at the same moment. The status byte can be read at any time, including during the busy period, and is also driven in parallel to the memory core.

Top module: `sr_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output is 0.
- R2: Opcode 0x06 followed by select rising with exactly 8 bits clocked in sets the enable latch (bit 1) one system clock after the select rise is seen, unless a write cycle is running.
- R3: After opcode 0x05, the status byte is shifted out MSB first on falling serial clock edges, starting at the falling edge after the eighth bit. It repeats every 8 bits and is refreshed at each byte start. The serial output is 0 while select is high.
- R4: Opcode 0x01 with exactly 16 bits, the enable latch set and no lock starts a write cycle. The busy bit (bit 0) reads 1 for exactly WCYC_CYCLES system clocks, starting the clock after the select rise is seen.
- R5: A status write whose select rise comes after any bit count other than 16 (for example 15 or 17) changes nothing.
- R6: A status write while the enable latch is clear changes nothing.
- R7: The status byte is locked when bit 7 is 1 and the protect pin is low. A locked status write changes nothing, and the enable latch keeps its value. With the pin high the same write is accepted.
- R8: Only data bits 7, 3 and 2 are stored, into status bits 7, 3 and 2. Status bits 6 to 4 always read 0, and the data bits at positions 6 to 4, 1 and 0 have no effect.
- R9: The new bits 7, 3 and 2 appear in the same clock in which the busy bit falls, and the enable latch clears in that clock. Before then the old values remain visible.
- R10: While a write cycle runs, further status writes are ignored and status reads return the byte with the busy bit set.
- R11: An unknown opcode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_wp_n | input | 1 | Active-low status write protect |
| spi_miso | output | 1 | Serial data out |
| status_o | output | 8 | Current status byte {lock, 0, 0, 0, prot1, prot0, enable latch, busy} |

## Verification
The stimulus covers write commands issued with and without the enable latch. It also covers select releases at 15, 16 and 17 bits, which separate the exact byte-boundary rule from a count that is merely "at least two bytes". Data bytes of all ones, 0x7F and 0x80 show which data bits reach the status byte. A locked write is sent once with the protect pin low and once with it high, which separates the lock condition from the bit 7 value alone. Reads and writes issued in the middle of a busy period show that the old bits stay visible, that writes are refused, and that the busy bit is reported on the serial output.

// File: rtl/sr_status_pkg.sv
package sr_status_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    localparam int BYTE_BITS = 8;

    // bit positions of the status byte
    localparam int ST_LOCK = 7;
    localparam int ST_BP1  = 3;
    localparam int ST_BP0  = 2;
    localparam int ST_WEL  = 1;
    localparam int ST_BUSY = 0;
endpackage

// File: rtl/sr_spi_rx.sv
module sr_spi_rx
    import sr_status_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             cs_n_i,
    input  logic             mosi_i,
    output logic             sck_fall_o,
    output logic             cs_rise_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [7:0]       opcode_o,
    output logic [7:0]       last_byte_o
);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    typedef struct packed {
        logic             sck;
        logic             cs_n;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       op;
        logic [7:0]       sh;
    } rx_t;

    rx_t  rx_q, rx_d;
    logic sck_rise;

    always_comb begin
        sck_rise   = !cs_n_i && sck_i && !rx_q.sck;
        sck_fall_o = !cs_n_i && !sck_i && rx_q.sck;
        cs_rise_o  = cs_n_i && !rx_q.cs_n;

        rx_d      = rx_q;
        rx_d.sck  = sck_i;
        rx_d.cs_n = cs_n_i;
        if (cs_n_i) begin
            rx_d.cnt = '0;
            rx_d.op  = '0;
            rx_d.sh  = '0;
        end else if (sck_rise) begin
            rx_d.sh = {rx_q.sh[6:0], mosi_i};
            if (rx_q.cnt != CNT_SAT) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
            if (rx_q.cnt == CNT_LAST) begin
                rx_d.op = {rx_q.sh[6:0], mosi_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.cs_n <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign bit_cnt_o   = rx_q.cnt;
    assign opcode_o    = rx_q.op;
    assign last_byte_o = rx_q.sh;
endmodule

// File: rtl/sr_miso_tx.sv
module sr_miso_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       fall_i,
    input  logic       active_i,
    input  logic [7:0] status_i,
    output logic       miso_o
);
    typedef struct packed {
        logic [2:0] idx;
        logic [7:0] snap;
        logic       miso;
    } tx_t;

    tx_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (cs_n_i) begin
            tx_d = '0;
        end else if (fall_i && active_i) begin
            if (tx_q.idx == 3'd0) begin
                tx_d.snap = status_i;
                tx_d.miso = status_i[7];
            end else begin
                tx_d.miso = tx_q.snap[~tx_q.idx];
            end
            tx_d.idx = tx_q.idx + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign miso_o = tx_q.miso;
endmodule

// File: rtl/sr_write_timer.sv
module sr_write_timer #(
    parameter int WCYC_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (WCYC_CYCLES > 1) ? $clog2(WCYC_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(WCYC_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_q, tm_d;

    always_comb begin
        tm_d   = tm_q;
        done_o = tm_q.busy && (tm_q.cnt == '0);
        if (tm_q.busy) begin
            if (tm_q.cnt == '0) begin
                tm_d.busy = 1'b0;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tm_d.busy = 1'b1;
            tm_d.cnt  = CNT_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign busy_o = tm_q.busy;
endmodule

// File: rtl/sr_status_ctrl.sv
module sr_status_ctrl
    import sr_status_pkg::*;
#(
    parameter int WCYC_CYCLES = 400,
    parameter int CNT_W       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       spi_wp_n,
    output logic       spi_miso,
    output logic [7:0] status_o
);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2 * BYTE_BITS);

    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
        logic       wel;
        logic       pend_lock;
        logic [1:0] pend_bp;
    } st_t;

    st_t st_q, st_d;

    logic             sck_fall, cs_rise, busy, done;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       opcode, last_byte, status_byte;
    logic             rd_active, locked, take_wren, take_wrsr;

    sr_spi_rx #(.CNT_W(CNT_W)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (spi_sck),
        .cs_n_i      (spi_cs_n),
        .mosi_i      (spi_mosi),
        .sck_fall_o  (sck_fall),
        .cs_rise_o   (cs_rise),
        .bit_cnt_o   (bit_cnt),
        .opcode_o    (opcode),
        .last_byte_o (last_byte)
    );

    sr_write_timer #(.WCYC_CYCLES(WCYC_CYCLES)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (take_wrsr),
        .busy_o  (busy),
        .done_o  (done)
    );

    sr_miso_tx tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (spi_cs_n),
        .fall_i   (sck_fall),
        .active_i (rd_active),
        .status_i (status_byte),
        .miso_o   (spi_miso)
    );

    always_comb begin
        status_byte          = '0;
        status_byte[ST_LOCK] = st_q.lock;
        status_byte[ST_BP1]  = st_q.bp[1];
        status_byte[ST_BP0]  = st_q.bp[0];
        status_byte[ST_WEL]  = st_q.wel;
        status_byte[ST_BUSY] = busy;

        rd_active = (bit_cnt >= CNT_CMD) && (opcode == OP_RDSR);
        locked    = st_q.lock && !spi_wp_n;
        take_wren = cs_rise && !busy && (bit_cnt == CNT_CMD) && (opcode == OP_WREN);
        take_wrsr = cs_rise && !busy && (bit_cnt == CNT_DATA) && (opcode == OP_WRSR)
                    && st_q.wel && !locked;

        st_d = st_q;
        if (take_wren) begin
            st_d.wel = 1'b1;
        end
        if (take_wrsr) begin
            st_d.pend_lock = last_byte[ST_LOCK];
            st_d.pend_bp   = {last_byte[ST_BP1], last_byte[ST_BP0]};
        end
        if (done) begin
            st_d.lock = st_q.pend_lock;
            st_d.bp   = st_q.pend_bp;
            st_d.wel  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = status_byte;
endmodule

// File: rtl/sr_status_chk.sv
module sr_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic [7:0] status_o
);
    // R8
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> ($past(spi_cs_n) && $past(status_o[1])));

    // R9
    prot_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({status_o[7], status_o[3:2]}) |-> $fell(status_o[0]));

    // R9
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> !status_o[1]);

    // R10
    wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && $past(status_o[0])) |-> status_o[1]);

    // R3
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso);
endmodule

bind sr_status_ctrl sr_status_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .status_o (status_o)
);

// File: tb/sr_status_ctrl_tb.sv
`timescale 1ns/1ps
module sr_status_ctrl_tb_top;
    localparam int WCYC = 400;
    localparam int H    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       wp_n = 1'b1;
    logic       miso;
    logic [7:0] status;

    always #2.5 clk = ~clk;

    sr_status_ctrl #(.WCYC_CYCLES(WCYC), .CNT_W(5)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (sck),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_wp_n (wp_n),
        .spi_miso (miso),
        .status_o (status)
    );

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit         m_bits[$];
    logic [7:0] m_op;
    int         m_falls, m_rem;
    logic [7:0] m_snap, m_pend;
    logic       m_miso, m_lock, m_wel, m_busy, m_sck_p, m_cs_p;
    logic [1:0] m_bp;

    function automatic logic [7:0] m_stat();
        return {m_lock, 3'b000, m_bp, m_wel, m_busy};
    endfunction

    always @(posedge clk) begin
        logic       ob;
        int         k;
        logic [7:0] v;
        if (!rst_n) begin
            m_bits.delete();
            m_op = 0; m_falls = 0; m_rem = 0; m_snap = 0; m_pend = 0;
            m_miso = 0; m_lock = 0; m_wel = 0; m_busy = 0; m_bp = 0;
            m_sck_p = 0; m_cs_p = 1;
        end else begin
            ob = m_busy;
            if (cs_n) begin
                m_miso = 0;
            end else if (!sck && m_sck_p) begin
                m_falls++;
                if (m_falls >= 8 && m_op == 8'h05) begin
                    k = (m_falls - 8) % 8;
                    if (k == 0) m_snap = m_stat();
                    m_miso = m_snap[7-k];
                end
            end else if (sck && !m_sck_p) begin
                m_bits.push_back(mosi);
                if (m_bits.size() == 8) begin
                    v = 0;
                    for (int i = 0; i < 8; i++) v = {v[6:0], m_bits[i]};
                    m_op = v;
                end
            end
            if (cs_n && !m_cs_p && !ob) begin
                if (m_bits.size() == 8 && m_op == 8'h06) m_wel = 1;
                if (m_bits.size() == 16 && m_op == 8'h01 && m_wel && !(m_lock && !wp_n)) begin
                    v = 0;
                    for (int i = 8; i < 16; i++) v = {v[6:0], m_bits[i]};
                    m_pend = v;
                    m_busy = 1;
                    m_rem = WCYC;
                end
            end
            if (cs_n) begin
                m_bits.delete();
                m_op = 0;
                m_falls = 0;
            end
            if (ob) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 0;
                    m_wel = 0;
                    m_lock = m_pend[7];
                    m_bp = m_pend[3:2];
                end
            end
            m_cs_p = cs_n;
            m_sck_p = sck;
        end
    end

    // per-clock comparison against the model, busy run length monitor
    int run_len = 0;
    int last_len = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(status === m_stat(), cur_req, {24'd0, status}, {24'd0, m_stat()});
            check(miso === m_miso, cur_req, {31'd0, miso}, {31'd0, m_miso});
            if (status[0]) run_len++;
            else if (run_len > 0) begin
                last_len = run_len;
                run_len = 0;
            end
        end
    end

    task automatic xfer(input logic [31:0] val, input int n, output logic [31:0] rx);
        rx = 0;
        @(negedge clk);
        cs_n = 0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = val[n-1-i];
            repeat (H) @(negedge clk);
            rx = {rx[30:0], miso};
            sck = 1;
            repeat (H) @(negedge clk);
            sck = 0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1;
        mosi = 0;
        repeat (H) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * WCYC && status[0]; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check(status == 8'h00, "R1", {24'd0, status}, 32'h0);
        check(miso == 1'b0, "R1", {31'd0, miso}, 32'h0);

        cur_req = "R3";
        xfer(32'h050000, 24, rx);
        check(rx[15:0] == 16'h0000, "R3", rx[15:0], 32'h0);

        cur_req = "R11";
        xfer(32'h04, 8, rx);
        check(status == 8'h00, "R11", {24'd0, status}, 32'h0);

        cur_req = "R6";
        xfer(32'h01FF, 16, rx);
        check(status == 8'h00, "R6", {24'd0, status}, 32'h0);

        cur_req = "R2";
        xfer(32'h06, 8, rx);
        check(status == 8'h02, "R2", {24'd0, status}, 32'h02);
        cur_req = "R3";
        xfer(32'h050000, 24, rx);
        check(rx[15:0] == 16'h0202, "R3", rx[15:0], 32'h0202);

        cur_req = "R5";
        xfer({17'd0, 8'h01, 7'h7F}, 15, rx);
        check(status == 8'h02, "R5", {24'd0, status}, 32'h02);
        xfer({15'd0, 8'h01, 8'hFF, 1'b1}, 17, rx);
        check(status == 8'h02, "R5", {24'd0, status}, 32'h02);

        cur_req = "R4";
        xfer(32'h01FF, 16, rx);
        check(status == 8'h03, "R4", {24'd0, status}, 32'h03);
        cur_req = "R10";
        xfer(32'h0100, 16, rx);
        xfer(32'h050000, 24, rx);
        check(rx[15:8] == 8'h03, "R10", rx[15:8], 32'h03);
        cur_req = "R9";
        wait_idle();
        check(status == 8'h8C, "R9", {24'd0, status}, 32'h8C);
        check(last_len == WCYC, "R4", last_len, WCYC);

        cur_req = "R7";
        xfer(32'h06, 8, rx);
        wp_n = 0;
        xfer(32'h0100, 16, rx);
        check(status == 8'h8E, "R7", {24'd0, status}, 32'h8E);
        wp_n = 1;
        xfer(32'h017F, 16, rx);
        check(status == 8'h8F, "R9", {24'd0, status}, 32'h8F);
        cur_req = "R8";
        wait_idle();
        check(status == 8'h0C, "R8", {24'd0, status}, 32'h0C);

        cur_req = "R7";
        xfer(32'h06, 8, rx);
        xfer(32'h0180, 16, rx);
        wait_idle();
        check(status == 8'h80, "R8", {24'd0, status}, 32'h80);
        wp_n = 0;
        xfer(32'h06, 8, rx);
        xfer(32'h0100, 16, rx);
        repeat (WCYC + 10) @(negedge clk);
        check(status == 8'h82, "R7", {24'd0, status}, 32'h82);
        wp_n = 1;
        repeat (5) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule